// File: doc/BRIEF.md
# Counter Host Register Port

This block is the host side of a 24-bit up/down counter. A processor reaches it over an 8-bit bidirectional data bus with active-low chip select, read and write strobes and a control/data select line. With the select line high, a write lands in one of four control registers, chosen by the two top data bits, and a read returns a status byte. With the select line low, writes feed a 24-bit preset register one byte at a time and reads fetch a 24-bit output latch one byte at a time. A single byte pointer, shared by both, walks byte 0, byte 1, byte 2.

All strobes, the select line and the bus are brought into the core clock domain through a synchronizer chain. Writes act on the synchronized falling edge of the write strobe. A latch read moves the pointer on the trailing (rising) edge of the read strobe, so the byte on the bus stays put for the whole read. Bits of the master-control register become one-cycle command pulses to the counter core, and one write may carry several of them. The counter core, its compare logic and its status flags sit outside this block and are reached through ports.

Top module: `cnt_host_port`

## Requirements
- R1: A control write (select high) with data bits 7:6 = 01 stores the input-control fields, with 10 stores bits 5:0 as the output mode, and with 11 stores bits 1:0 as the quadrature mode. Input-control fields are: bit 0 clock-plus-direction, bit 3 input enable, bit 4 gate-instead-of-reset, bit 5 latch-load-instead-of-counter-load.
- R2: A data write (select low) stores the byte into preset byte `ptr`, where preset byte k is bits 8k+7:8k, and then advances the pointer.
- R3: A data read (select low) drives output-latch byte `ptr` on the bus, and the pointer advances when the read ends.
- R4: The pointer stops at byte 2: further data writes overwrite byte 2 and further latch reads return byte 2.
- R5: Master control (bits 7:6 = 00): bit 0 returns the pointer to byte 0, and bit 1 copies `cnt_in` into the output latch. The pointer is shared, so a preset write moves the next latch read on by one byte.
- R6: Master-control bit 2 gives one `cmd_cnt_clear` pulse, bit 3 one `cmd_cnt_load` pulse and bit 4 one `cmd_cmp_clear` pulse, each exactly one cycle long per write. Several bits in one write fire together, and no follow-up write of zero is needed.
- R7: Master-control bit 5 clears every control field, the output latch and the pointer, sets the preset to all ones, and gives one `cmd_master` pulse. A latch copy (bit 1) in the same write wins over the latch clear.
- R8: Input-control bit 1 gives one `in_step_inc` pulse and bit 2 one `in_step_dec` pulse per write. Neither bit is stored.
- R9: A control read (select high) returns `{3'b000, stat_in}` and does not move the pointer.
- R10: While `cs_n` is high, strobes change no register and no pointer, and the bus is not driven.
- R11: The bus is high impedance unless `cs_n` and `rd_n` are both low.
- R12: After reset all control fields and the latch are zero, the preset is all ones, the pointer is at byte 0 and no command pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | High: control/status, low: preset/latch |
| bus_d | inout | 8 | Bidirectional host data bus |
| cnt_in | input | 24 | Live counter value from the core |
| stat_in | input | 5 | Status flags from the core |
| preset_o | output | 24 | Preset register contents |
| in_dir_mode | output | 1 | Clock-plus-direction input mode |
| in_step_inc | output | 1 | One-cycle single increment request |
| in_step_dec | output | 1 | One-cycle single decrement request |
| in_enable | output | 1 | Count inputs enabled |
| in_gate_sel | output | 1 | Shared pin acts as count gate |
| in_latch_sel | output | 1 | Load pin acts as latch load |
| out_mode | output | 6 | Output/counter mode field |
| quad_mode | output | 2 | Quadrature mode field |
| cmd_cnt_clear | output | 1 | One-cycle counter clear command |
| cmd_cnt_load | output | 1 | One-cycle counter load-from-preset command |
| cmd_cmp_clear | output | 1 | One-cycle compare-toggle clear command |
| cmd_master | output | 1 | One-cycle master reset command |

## Verification
The master reset and the latch copy can act in the same cycle, because both come from one master-control write. The bench provokes this with a single write of 0x22, after it has filled the control registers and moved the pointer to byte 2. It judges the result by reading three latch bytes from byte 0: they must give the live counter value, not zero, while the control fields come back as zero and the preset as all ones. The pointer reset and the latch copy are also fired together (0x03). A lone preset write then sits between that copy and a latch read, to show that one pointer serves both.

// File: rtl/cnt_host_pkg.sv
// Package: shared encodings for the counter host port.
// Assumes an 8-bit bus whose top two bits select a control register.
package cnt_host_pkg;

    typedef enum logic [1:0] {
        SEL_MASTER = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_OUTPUT = 2'b10,
        SEL_QUAD   = 2'b11
    } ctl_sel_e;

    // Master-control bit positions
    localparam int MC_PTR_RST  = 0;
    localparam int MC_LATCH    = 1;
    localparam int MC_CNT_CLR  = 2;
    localparam int MC_CNT_LOAD = 3;
    localparam int MC_CMP_CLR  = 4;
    localparam int MC_MASTER   = 5;

    // Input-control bit positions
    localparam int IC_DIR_MODE = 0;
    localparam int IC_INC      = 1;
    localparam int IC_DEC      = 2;
    localparam int IC_ENABLE   = 3;
    localparam int IC_GATE     = 4;
    localparam int IC_LATCH    = 5;

endpackage

// File: rtl/cnt_host_sync.sv
// Module: cnt_host_sync
// Brings a bundle of asynchronous host pins into the clock domain through
// a chain of STAGES flops. Assumes the data pins are stable while a strobe
// is asserted, so they may share the chain with the strobes.
module cnt_host_sync #(
    parameter int          W       = 12,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain [STAGES];

    // Shift the pin bundle through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= async_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/cnt_host_regs.sv
// Module: cnt_host_regs
// Decodes control writes into the input, output and quadrature registers and
// turns master/input-control bits into one-cycle command pulses. It also
// emits same-cycle action strobes for the byte port. Assumes wr_ctl is a
// single-cycle event.
module cnt_host_regs
    import cnt_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic              in_dir_mode,
    output logic              in_enable,
    output logic              in_gate_sel,
    output logic              in_latch_sel,
    output logic              in_step_inc,
    output logic              in_step_dec,
    output logic [DATA_W-3:0] out_mode,
    output logic [1:0]        quad_mode,
    output logic              cmd_cnt_clear,
    output logic              cmd_cnt_load,
    output logic              cmd_cmp_clear,
    output logic              cmd_master,
    output logic              act_ptr_rst,
    output logic              act_latch,
    output logic              act_mreset
);

    localparam int FLD_W = DATA_W - 2;

    ctl_sel_e sel;
    logic     is_mc, is_ic, is_oc, is_qd;

    // Register select from the top two data bits
    always_comb begin
        sel   = ctl_sel_e'(wdata[DATA_W-1 -: 2]);
        is_mc = wr_ctl && (sel == SEL_MASTER);
        is_ic = wr_ctl && (sel == SEL_INPUT);
        is_oc = wr_ctl && (sel == SEL_OUTPUT);
        is_qd = wr_ctl && (sel == SEL_QUAD);
    end

    assign act_mreset  = is_mc && wdata[MC_MASTER];
    assign act_ptr_rst = is_mc && (wdata[MC_PTR_RST] || wdata[MC_MASTER]);
    assign act_latch   = is_mc && wdata[MC_LATCH];

    // Command pulses: high for the single cycle after the write event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_cnt_clear <= 1'b0;
            cmd_cnt_load  <= 1'b0;
            cmd_cmp_clear <= 1'b0;
            cmd_master    <= 1'b0;
            in_step_inc   <= 1'b0;
            in_step_dec   <= 1'b0;
        end else begin
            cmd_cnt_clear <= is_mc && wdata[MC_CNT_CLR];
            cmd_cnt_load  <= is_mc && wdata[MC_CNT_LOAD];
            cmd_cmp_clear <= is_mc && wdata[MC_CMP_CLR];
            cmd_master    <= act_mreset;
            in_step_inc   <= is_ic && wdata[IC_INC];
            in_step_dec   <= is_ic && wdata[IC_DEC];
        end
    end

    // Stored control fields, cleared by reset or by master reset
    always_ff @(posedge clk) begin
        if (!rst_n || act_mreset) begin
            in_dir_mode  <= 1'b0;
            in_enable    <= 1'b0;
            in_gate_sel  <= 1'b0;
            in_latch_sel <= 1'b0;
            out_mode     <= '0;
            quad_mode    <= 2'b00;
        end else begin
            if (is_ic) begin
                in_dir_mode  <= wdata[IC_DIR_MODE];
                in_enable    <= wdata[IC_ENABLE];
                in_gate_sel  <= wdata[IC_GATE];
                in_latch_sel <= wdata[IC_LATCH];
            end
            if (is_oc) out_mode  <= wdata[FLD_W-1:0];
            if (is_qd) quad_mode <= wdata[1:0];
        end
    end

    a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt_load |=> !cmd_cnt_load);
    a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt_clear |=> !cmd_cnt_clear);
    a_r8_inc_single: assert property (@(posedge clk) disable iff (!rst_n)
        in_step_inc |=> !in_step_inc);
    a_r7_fields_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        act_mreset |=> (out_mode == '0 && quad_mode == 2'b00 && !in_enable
                        && !in_dir_mode && !in_gate_sel && !in_latch_sel));
    a_r1_quad_store: assert property (@(posedge clk) disable iff (!rst_n)
        is_qd |=> quad_mode == $past(wdata[1:0]));

endmodule

// File: rtl/cnt_host_bytes.sv
// Module: cnt_host_bytes
// Holds the preset register and the output latch as byte arrays, with one
// byte pointer that serves both. The pointer stops at the last byte. Data
// writes advance it at once, latch reads advance it when the read ends.
// Assumes the events arrive as single-cycle pulses.
module cnt_host_bytes #(
    parameter int DATA_W = 8,
    parameter int BYTES  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_data,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     rd_start,
    input  logic                     rd_end,
    input  logic                     act_ptr_rst,
    input  logic                     act_latch,
    input  logic                     act_mreset,
    input  logic [DATA_W*BYTES-1:0]  cnt_in,
    output logic [DATA_W*BYTES-1:0]  preset_o,
    output logic [DATA_W-1:0]        latch_byte
);

    localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BYTES - 1);

    logic [DATA_W-1:0] pre_b   [BYTES];
    logic [DATA_W-1:0] latch_b [BYTES];
    logic [PTR_W-1:0]  ptr;
    logic              rd_pend;

    // Preset and latch storage; a latch copy overrides the master clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                pre_b[i]   <= '1;
                latch_b[i] <= '0;
            end
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                if (act_mreset) begin
                    pre_b[i]   <= '1;
                    latch_b[i] <= '0;
                end
                if (act_latch) latch_b[i] <= cnt_in[i*DATA_W +: DATA_W];
                if (wr_data && ptr == PTR_W'(i)) pre_b[i] <= wdata;
            end
        end
    end

    // Shared byte pointer with saturation at the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            rd_pend <= 1'b0;
        end else begin
            if (rd_start)    rd_pend <= 1'b1;
            else if (rd_end) rd_pend <= 1'b0;
            if (act_ptr_rst)
                ptr <= '0;
            else if ((wr_data || (rd_end && rd_pend)) && ptr != LAST)
                ptr <= ptr + 1'b1;
        end
    end

    // Latch byte selected by the pointer
    always_comb begin
        latch_byte = '0;
        for (int i = 0; i < BYTES; i++)
            if (ptr == PTR_W'(i)) latch_byte = latch_b[i];
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_flat
        assign preset_o[g*DATA_W +: DATA_W] = pre_b[g];
    end

    a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data || rd_end || act_ptr_rst) |=> $stable(ptr));
    a_r7_preset_ones: assert property (@(posedge clk) disable iff (!rst_n)
        act_mreset |=> preset_o == '1);
    a_r2_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr == '0) |=> pre_b[0] == $past(wdata));
    a_r5_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        act_ptr_rst |=> ptr == '0);

endmodule

// File: rtl/cnt_host_port.sv
// Module: cnt_host_port (top)
// Byte-wide host register port for a 24-bit counter. It synchronizes the
// host pins, detects strobe edges, routes control writes to the register
// decoder and data transfers to the byte store, and drives the bus only
// while the chip is selected and read is low. Assumes the host holds data
// and select lines steady while a strobe is low.
module cnt_host_port #(
    parameter int DATA_W      = 8,
    parameter int BYTES       = 3,
    parameter int STAT_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic                    cd_sel,
    inout  wire  [DATA_W-1:0]       bus_d,
    input  logic [DATA_W*BYTES-1:0] cnt_in,
    input  logic [STAT_W-1:0]       stat_in,
    output logic [DATA_W*BYTES-1:0] preset_o,
    output logic                    in_dir_mode,
    output logic                    in_step_inc,
    output logic                    in_step_dec,
    output logic                    in_enable,
    output logic                    in_gate_sel,
    output logic                    in_latch_sel,
    output logic [DATA_W-3:0]       out_mode,
    output logic [1:0]              quad_mode,
    output logic                    cmd_cnt_clear,
    output logic                    cmd_cnt_load,
    output logic                    cmd_cmp_clear,
    output logic                    cmd_master
);

    localparam int SW = DATA_W + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

    logic [SW-1:0]     s_bus;
    logic              s_cs_n, s_cd, s_rd_n, s_wr_n;
    logic [DATA_W-1:0] s_data;
    logic              rd_prev, wr_prev;
    logic              wr_evt, rd_fall, rd_rise;
    logic              act_ptr_rst, act_latch, act_mreset;
    logic [DATA_W-1:0] latch_byte, rd_byte;
    logic              bus_oe;

    cnt_host_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, cd_sel, rd_n, wr_n, bus_d}),
        .sync_o  (s_bus)
    );

    assign {s_cs_n, s_cd, s_rd_n, s_wr_n, s_data} = s_bus;

    // Previous synchronized strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b1;
            wr_prev <= 1'b1;
        end else begin
            rd_prev <= s_rd_n;
            wr_prev <= s_wr_n;
        end
    end

    assign wr_evt  = wr_prev && !s_wr_n && !s_cs_n;
    assign rd_fall = rd_prev && !s_rd_n && !s_cs_n;
    assign rd_rise = !rd_prev && s_rd_n;

    cnt_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ctl        (wr_evt && s_cd),
        .wdata         (s_data),
        .in_dir_mode   (in_dir_mode),
        .in_enable     (in_enable),
        .in_gate_sel   (in_gate_sel),
        .in_latch_sel  (in_latch_sel),
        .in_step_inc   (in_step_inc),
        .in_step_dec   (in_step_dec),
        .out_mode      (out_mode),
        .quad_mode     (quad_mode),
        .cmd_cnt_clear (cmd_cnt_clear),
        .cmd_cnt_load  (cmd_cnt_load),
        .cmd_cmp_clear (cmd_cmp_clear),
        .cmd_master    (cmd_master),
        .act_ptr_rst   (act_ptr_rst),
        .act_latch     (act_latch),
        .act_mreset    (act_mreset)
    );

    cnt_host_bytes #(.DATA_W(DATA_W), .BYTES(BYTES)) u_bytes (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data     (wr_evt && !s_cd),
        .wdata       (s_data),
        .rd_start    (rd_fall && !s_cd),
        .rd_end      (rd_rise),
        .act_ptr_rst (act_ptr_rst),
        .act_latch   (act_latch),
        .act_mreset  (act_mreset),
        .cnt_in      (cnt_in),
        .preset_o    (preset_o),
        .latch_byte  (latch_byte)
    );

    // Read data: status byte in control space, latch byte in data space
    assign rd_byte = cd_sel ? {{(DATA_W-STAT_W){1'b0}}, stat_in} : latch_byte;
    assign bus_oe  = !cs_n && !rd_n;
    assign bus_d   = bus_oe ? rd_byte : {DATA_W{1'bz}};

    a_r10_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |-> !wr_evt && !rd_fall);
    a_r7_master_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        act_mreset |=> cmd_master);

endmodule

// File: tb/sim_cnt_host_port.sv
// Bench for cnt_host_port: sweeps every control-register value and every
// status value, and walks the byte pointer through fills, saturation and
// combined master-control writes. Expected values are computed here.
module sim_cnt_host_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_sel = 1'b0;
    logic [7:0]  drv = 8'h00;
    logic        drv_en = 1'b0;
    tri   [7:0]  bus_w;
    logic [23:0] cnt_in = 24'h0;
    logic [4:0]  stat_in = 5'h0;
    logic [23:0] preset_o;
    logic        in_dir_mode, in_step_inc, in_step_dec, in_enable, in_gate_sel, in_latch_sel;
    logic [5:0]  out_mode;
    logic [1:0]  quad_mode;
    logic        cmd_cnt_clear, cmd_cnt_load, cmd_cmp_clear, cmd_master;

    int checks = 0, errors = 0;
    int n_clr = 0, n_load = 0, n_cmp = 0, n_mst = 0, n_inc = 0, n_dec = 0;
    bit done = 1'b0;

    assign bus_w = drv_en ? drv : 8'hzz;

    always #2 clk = ~clk;

    cnt_host_port u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .cd_sel(cd_sel), .bus_d(bus_w), .cnt_in(cnt_in), .stat_in(stat_in),
        .preset_o(preset_o), .in_dir_mode(in_dir_mode), .in_step_inc(in_step_inc),
        .in_step_dec(in_step_dec), .in_enable(in_enable), .in_gate_sel(in_gate_sel),
        .in_latch_sel(in_latch_sel), .out_mode(out_mode), .quad_mode(quad_mode),
        .cmd_cnt_clear(cmd_cnt_clear), .cmd_cnt_load(cmd_cnt_load),
        .cmd_cmp_clear(cmd_cmp_clear), .cmd_master(cmd_master)
    );

    // Count pulse cycles away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_clr += int'(cmd_cnt_clear);
            n_load += int'(cmd_cnt_load);
            n_cmp += int'(cmd_cmp_clear);
            n_mst += int'(cmd_master);
            n_inc += int'(in_step_inc);
            n_dec += int'(in_step_dec);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic cs, input logic cd, input logic [7:0] d);
        @(negedge clk);
        cs_n = cs; cd_sel = cd; drv = d; drv_en = 1'b1;
        wait_n(2); wr_n = 1'b0;
        wait_n(4); wr_n = 1'b1;
        wait_n(4); drv_en = 1'b0; cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic bus_read(input logic cs, input logic cd, output logic [7:0] q);
        @(negedge clk);
        cs_n = cs; cd_sel = cd;
        wait_n(2); rd_n = 1'b0;
        wait_n(4); q = bus_w;
        rd_n = 1'b1;
        wait_n(4); cs_n = 1'b1;
        wait_n(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int b_inc, b_dec;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);

        // R12 reset state
        chk("R12 preset", 32'(preset_o), 32'hFFFFFF);
        chk("R12 fields", {in_dir_mode, in_enable, in_gate_sel, in_latch_sel, out_mode, quad_mode}, 0);
        chk("R12 pulses", n_clr + n_load + n_cmp + n_mst + n_inc + n_dec, 0);
        // R11 bus released while idle
        chk("R11 idle z", 32'(bus_w === 8'hzz), 1);

        // R1 output-mode sweep
        for (int v = 0; v < 64; v++) begin
            bus_write(1'b0, 1'b1, 8'h80 | 8'(v));
            chk("R1 out_mode", 32'(out_mode), 32'(v));
        end
        // R1 quadrature sweep
        for (int v = 0; v < 4; v++) begin
            bus_write(1'b0, 1'b1, 8'hC0 | 8'(v) | 8'h3C);
            chk("R1 quad_mode", 32'(quad_mode), 32'(v));
        end
        // R1/R8 input-control sweep
        for (int v = 0; v < 64; v++) begin
            b_inc = n_inc; b_dec = n_dec;
            bus_write(1'b0, 1'b1, 8'h40 | 8'(v));
            chk("R1 in fields", {in_dir_mode, in_enable, in_gate_sel, in_latch_sel},
                {v[0], v[3], v[4], v[5]});
            chk("R8 inc pulse", n_inc - b_inc, 32'(v[1]));
            chk("R8 dec pulse", n_dec - b_dec, 32'(v[2]));
        end

        // R6 combined commands in one write, no zero write afterwards
        bus_write(1'b0, 1'b1, 8'h1C);
        chk("R6 clear", n_clr, 1);
        chk("R6 load", n_load, 1);
        chk("R6 cmp", n_cmp, 1);
        chk("R6 master none", n_mst, 0);
        bus_write(1'b0, 1'b1, 8'h08);
        chk("R6 load again", n_load, 2);
        chk("R6 clear idle", n_clr, 1);

        // R2/R4 preset fill and saturation
        bus_write(1'b0, 1'b1, 8'h01);
        bus_write(1'b0, 1'b0, 8'h11);
        bus_write(1'b0, 1'b0, 8'h22);
        bus_write(1'b0, 1'b0, 8'h33);
        chk("R2 preset fill", 32'(preset_o), 32'h332211);
        bus_write(1'b0, 1'b0, 8'h44);
        chk("R4 preset saturate", 32'(preset_o), 32'h442211);

        // R3/R4/R5 latch capture and read-out, several patterns
        for (int p = 0; p < 4; p++) begin
            logic [23:0] pat;
            pat = 24'h5A3C96 ^ (24'h1F0E0D * 24'(p + 1));
            cnt_in = pat;
            bus_write(1'b0, 1'b1, 8'h03);
            cnt_in = ~pat;
            for (int b = 0; b < 3; b++) begin
                bus_read(1'b0, 1'b0, q);
                chk("R3 latch byte", 32'(q), 32'(pat[b*8 +: 8]));
            end
            bus_read(1'b0, 1'b0, q);
            chk("R4 read saturate", 32'(q), 32'(pat[23:16]));
        end

        // R5 shared pointer: a preset write moves the next latch read
        cnt_in = 24'hA1B2C3;
        bus_write(1'b0, 1'b1, 8'h03);
        bus_write(1'b0, 1'b0, 8'h55);
        bus_read(1'b0, 1'b0, q);
        chk("R5 shared ptr", 32'(q), 32'hB2);
        chk("R5 preset byte0", 32'(preset_o[7:0]), 32'h55);

        // R9 status sweep; pointer must not move
        bus_write(1'b0, 1'b1, 8'h01);
        for (int s = 0; s < 32; s++) begin
            stat_in = 5'(s);
            bus_read(1'b0, 1'b1, q);
            chk("R9 status", 32'(q), 32'(s));
        end
        bus_read(1'b0, 1'b0, q);
        chk("R9 ptr kept", 32'(q), 32'hC3);

        // R10 deselected bus activity
        bus_write(1'b0, 1'b1, 8'h80 | 8'h15);
        bus_write(1'b1, 1'b1, 8'h80 | 8'h2A);
        chk("R10 out_mode kept", 32'(out_mode), 32'h15);
        bus_write(1'b0, 1'b1, 8'h01);
        bus_write(1'b1, 1'b0, 8'h77);
        chk("R10 preset kept", 32'(preset_o[7:0]), 32'h55);
        bus_read(1'b1, 1'b0, q);
        chk("R10 bus z", 32'(q === 8'hzz), 1);
        bus_read(1'b0, 1'b0, q);
        chk("R10 ptr kept", 32'(q), 32'hC3);
        chk("R11 after read z", 32'(bus_w === 8'hzz), 1);

        // R7 master reset combined with latch copy
        bus_write(1'b0, 1'b1, 8'h40 | 8'h39);
        bus_write(1'b0, 1'b1, 8'hC3);
        bus_write(1'b0, 1'b0, 8'h66);
        bus_write(1'b0, 1'b0, 8'h67);
        cnt_in = 24'h0F1E2D;
        bus_write(1'b0, 1'b1, 8'h22);
        chk("R7 preset ones", 32'(preset_o), 32'hFFFFFF);
        chk("R7 fields zero", {in_dir_mode, in_enable, in_gate_sel, in_latch_sel, out_mode, quad_mode}, 0);
        chk("R7 master pulse", n_mst, 1);
        for (int b = 0; b < 3; b++) begin
            bus_read(1'b0, 1'b0, q);
            chk("R7 latch wins", 32'(q), 32'(cnt_in[b*8 +: 8]));
        end
        // R7 master reset alone clears the latch
        bus_write(1'b0, 1'b1, 8'h20);
        bus_read(1'b0, 1'b0, q);
        chk("R7 latch cleared", 32'(q), 0);
        chk("R7 master pulse 2", n_mst, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule